// File: doc/BRIEF.md
# Miss-Stride Prefetch Engine

This block watches the stream of cache misses and spots a constant stride between consecutive misses of the same context. It does not use a program counter. For each context it keeps two history registers: the most recent miss block address and the one before it. On every miss it compares the fresh delta (current block minus last) with the older delta (last minus the one before). When the two deltas are equal, it proposes a fixed number of prefetch candidates spaced by that stride. All candidates carry one latency value, which a downstream prefetch queue uses to schedule them.

The miss port takes a byte address, which the block aligns to a cache block, together with a context number. A mode input chooses between separate history per context and one shared history. A second mode input stops candidate generation at the boundary of the current virtual page. In that case a running counter totals the candidates that were dropped. Candidates appear as a lane vector one clock after the miss. Lane i holds step i+1, and the lane-valid bits always form a contiguous run that starts at lane 0.

Top module: `stride_miss_pf`

## Requirements
- R1: Reset clears `pf_valid`, `pf_lat`, `span_total` and every history register to zero. Because history starts at zero, a first miss to block address 0 in any context sees two equal strides of zero and emits DEGREE candidates at address 0.
- R2: A miss fires when (block − last) equals (last − previous) for the selected context. The subtraction wraps modulo 2^ADDR_W, so the stride is read as signed. When the deltas differ, `pf_valid` is all zero in the next cycle.
- R3: When a miss fires, lane i (0-based) of `pf_addr`, bits [i*ADDR_W +: ADDR_W], holds block + (i+1)·stride modulo 2^ADDR_W. It appears on the output in the clock cycle after the miss is sampled.
- R4: Every accepted miss moves the last address into the previous slot and writes its own block address as last. The strides are formed from the history as it stood before this update. A miss to the same context in the very next cycle already sees the update.
- R5: The low BLK_BITS bits of `miss_addr` are ignored. All arithmetic uses the block-aligned address.
- R6: With `per_ctx_en` high, `miss_ctx` selects an independent history. With it low, `miss_ctx` is ignored and context 0 is used.
- R7: With `page_stop_en` high, the first lane whose address differs from the block address in bits [ADDR_W-1:PAGE_BITS] is invalid, and so is every later lane. `pf_valid` is therefore always a prefix mask.
- R8: On a firing miss with `page_stop_en` high, `span_total` grows by the number of suppressed lanes (DEGREE minus the valid count). The counter wraps at 2^SPAN_W and is visible one cycle after the miss.
- R9: With `page_stop_en` low, a firing miss makes all DEGREE lanes valid and `span_total` does not change.
- R10: `pf_lat` takes the value of `lat_cfg` sampled with each accepted miss and keeps it until the next accepted miss.
- R11: A cycle without `miss_valid` produces `pf_valid` = 0 in the next cycle and leaves all history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A miss is presented this cycle |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_ctx | input | CTX_W | Context number of the miss |
| per_ctx_en | input | 1 | 1: history per context, 0: shared history in context 0 |
| page_stop_en | input | 1 | 1: stop candidates at the page boundary |
| lat_cfg | input | LAT_W | Latency attached to candidates |
| pf_valid | output | DEGREE | Lane valid bits, a prefix mask |
| pf_addr | output | DEGREE*ADDR_W | Candidate addresses, lane i at [i*ADDR_W +: ADDR_W] |
| pf_lat | output | LAT_W | Latency of the current candidates |
| span_total | output | SPAN_W | Wrapping count of candidates dropped at page boundaries |

## Verification
Two things can happen in one cycle: the history update of a miss and the stride read for the next miss to the same context. The bench provokes this by feeding three-miss stride runs with no idle cycle between them, so each miss must see the write made one edge earlier. A second collision is the page-boundary cut and the counter step for that same miss. Stride sweeps start near page edges, so the emitted prefix and the counter step are judged in the same output cycle against an arithmetic model of the requirements.

// File: rtl/stride_pf_pkg.sv
package stride_pf_pkg;

  localparam int unsigned DEF_ADDR_W    = 32;
  localparam int unsigned DEF_CTX_N     = 64;
  localparam int unsigned DEF_DEGREE    = 4;
  localparam int unsigned DEF_PAGE_BITS = 12;
  localparam int unsigned DEF_BLK_BITS  = 6;
  localparam int unsigned DEF_LAT_W     = 16;
  localparam int unsigned DEF_SPAN_W    = 32;

  // width needed to index n items (at least one bit)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/stride_pf_hist.sv
// Per-context two-deep miss history. Asynchronous read, synchronous write.
module stride_pf_hist #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CTX_N  = 64,
  parameter int unsigned CTX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTX_W-1:0]  idx,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_prev,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_blk
);

  logic [ADDR_W-1:0] last_mem [CTX_N];
  logic [ADDR_W-1:0] prev_mem [CTX_N];

  assign rd_last = last_mem[idx];
  assign rd_prev = prev_mem[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(CTX_N); k++) begin
        last_mem[k] <= '0;
        prev_mem[k] <= '0;
      end
    end else if (wr_en) begin
      prev_mem[idx] <= last_mem[idx];
      last_mem[idx] <= wr_blk;
    end
  end

endmodule

// File: rtl/stride_pf_lanes.sv
// Candidate address generation, page-boundary cut and dropped-lane count.
module stride_pf_lanes #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DEGREE    = 4,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned INC_W     = 3
) (
  input  logic [ADDR_W-1:0]        base,
  input  logic [ADDR_W-1:0]        stride,
  input  logic                     fire,
  input  logic                     page_stop,
  output logic [DEGREE-1:0]        lane_valid,
  output logic [DEGREE*ADDR_W-1:0] lane_addr,
  output logic [INC_W-1:0]         span_inc
);

  logic [DEGREE-1:0] leaves;

  generate
    for (genvar i = 0; i < int'(DEGREE); i++) begin : g_lane
      logic [ADDR_W-1:0] cand;
      assign cand = base + stride * ADDR_W'(i + 1);
      assign lane_addr[i*ADDR_W +: ADDR_W] = cand;
      assign leaves[i] = cand[ADDR_W-1:PAGE_BITS] != base[ADDR_W-1:PAGE_BITS];
    end
  endgenerate

  logic             blocked;
  logic [INC_W-1:0] kept;

  always_comb begin
    blocked    = 1'b0;
    kept       = '0;
    lane_valid = '0;
    for (int i = 0; i < int'(DEGREE); i++) begin
      blocked       = blocked | (page_stop & leaves[i]);
      lane_valid[i] = fire & ~blocked;
      kept          = kept + INC_W'(lane_valid[i]);
    end
    span_inc = (fire && page_stop) ? (INC_W'(DEGREE) - kept) : '0;
  end

endmodule

// File: rtl/stride_miss_pf.sv
module stride_miss_pf #(
  parameter int unsigned ADDR_W    = stride_pf_pkg::DEF_ADDR_W,
  parameter int unsigned CTX_N     = stride_pf_pkg::DEF_CTX_N,
  parameter int unsigned DEGREE    = stride_pf_pkg::DEF_DEGREE,
  parameter int unsigned PAGE_BITS = stride_pf_pkg::DEF_PAGE_BITS,
  parameter int unsigned BLK_BITS  = stride_pf_pkg::DEF_BLK_BITS,
  parameter int unsigned LAT_W     = stride_pf_pkg::DEF_LAT_W,
  parameter int unsigned SPAN_W    = stride_pf_pkg::DEF_SPAN_W,
  parameter int unsigned CTX_W     = stride_pf_pkg::idx_bits(CTX_N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     miss_valid,
  input  logic [ADDR_W-1:0]        miss_addr,
  input  logic [CTX_W-1:0]         miss_ctx,
  input  logic                     per_ctx_en,
  input  logic                     page_stop_en,
  input  logic [LAT_W-1:0]         lat_cfg,
  output logic [DEGREE-1:0]        pf_valid,
  output logic [DEGREE*ADDR_W-1:0] pf_addr,
  output logic [LAT_W-1:0]         pf_lat,
  output logic [SPAN_W-1:0]        span_total
);

  localparam int unsigned INC_W = stride_pf_pkg::idx_bits(DEGREE + 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << BLK_BITS) - ADDR_W'(1));

  logic [CTX_W-1:0]  ctx_sel;
  logic [ADDR_W-1:0] blk;
  logic [ADDR_W-1:0] h_last, h_prev;
  logic [ADDR_W-1:0] d_new, d_old;
  logic              fire;

  assign ctx_sel = per_ctx_en ? miss_ctx : '0;
  assign blk     = miss_addr & BLK_MASK;

  stride_pf_hist #(
    .ADDR_W (ADDR_W),
    .CTX_N  (CTX_N),
    .CTX_W  (CTX_W)
  ) u_hist (
    .clk     (clk),
    .rst     (rst),
    .idx     (ctx_sel),
    .rd_last (h_last),
    .rd_prev (h_prev),
    .wr_en   (miss_valid),
    .wr_blk  (blk)
  );

  assign d_new = blk - h_last;
  assign d_old = h_last - h_prev;
  assign fire  = miss_valid && (d_new == d_old);

  logic [DEGREE-1:0]        nxt_valid;
  logic [DEGREE*ADDR_W-1:0] nxt_addr;
  logic [INC_W-1:0]         nxt_inc;

  stride_pf_lanes #(
    .ADDR_W    (ADDR_W),
    .DEGREE    (DEGREE),
    .PAGE_BITS (PAGE_BITS),
    .INC_W     (INC_W)
  ) u_lanes (
    .base       (blk),
    .stride     (d_new),
    .fire       (fire),
    .page_stop  (page_stop_en),
    .lane_valid (nxt_valid),
    .lane_addr  (nxt_addr),
    .span_inc   (nxt_inc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid   <= '0;
      pf_addr    <= '0;
      pf_lat     <= '0;
      span_total <= '0;
    end else begin
      pf_valid   <= nxt_valid;
      span_total <= span_total + SPAN_W'(nxt_inc);
      if (fire) pf_addr <= nxt_addr;
      if (miss_valid) pf_lat <= lat_cfg;
    end
  end

endmodule

// File: rtl/stride_miss_pf_chk.sv
module stride_miss_pf_chk #(
  parameter int unsigned DEGREE = 4,
  parameter int unsigned LAT_W  = 16,
  parameter int unsigned SPAN_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              page_stop_en,
  input logic [LAT_W-1:0]  lat_cfg,
  input logic [DEGREE-1:0] pf_valid,
  input logic [LAT_W-1:0]  pf_lat,
  input logic [SPAN_W-1:0] span_total
);

  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> (pf_valid == '0)); // R11

  AST_LANES_PREFIX: assert property (@(posedge clk) disable iff (rst)
    ((pf_valid & (pf_valid + DEGREE'(1))) == '0)); // R7

  AST_ALL_LANES_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !page_stop_en) |=> (pf_valid == '0 || (&pf_valid))); // R9

  AST_SPAN_HELD: assert property (@(posedge clk) disable iff (rst)
    !(miss_valid && page_stop_en) |=> (span_total == $past(span_total))); // R8

  AST_SPAN_STEP: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && page_stop_en) |=> (pf_valid == '0 ||
      (span_total - $past(span_total)) == SPAN_W'(DEGREE - $countones(pf_valid)))); // R8

  AST_LAT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    miss_valid |=> (pf_lat == $past(lat_cfg))); // R10

endmodule

bind stride_miss_pf stride_miss_pf_chk #(
  .DEGREE (DEGREE),
  .LAT_W  (LAT_W),
  .SPAN_W (SPAN_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .miss_valid   (miss_valid),
  .page_stop_en (page_stop_en),
  .lat_cfg      (lat_cfg),
  .pf_valid     (pf_valid),
  .pf_lat       (pf_lat),
  .span_total   (span_total)
);

// File: tb/stride_miss_pf_test.sv
module stride_miss_pf_test;

  localparam int AW = 16;
  localparam int CN = 4;
  localparam int DG = 3;
  localparam int PB = 8;
  localparam int BB = 2;
  localparam int LW = 8;
  localparam int SW = 6;

  logic              clk = 1'b0;
  logic              rst;
  logic              miss_valid;
  logic [AW-1:0]     miss_addr;
  logic [1:0]        miss_ctx;
  logic              per_ctx_en;
  logic              page_stop_en;
  logic [LW-1:0]     lat_cfg;
  logic [DG-1:0]     pf_valid;
  logic [DG*AW-1:0]  pf_addr;
  logic [LW-1:0]     pf_lat;
  logic [SW-1:0]     span_total;

  always #4 clk = ~clk;  // 125 MHz

  stride_miss_pf #(
    .ADDR_W(AW), .CTX_N(CN), .DEGREE(DG), .PAGE_BITS(PB),
    .BLK_BITS(BB), .LAT_W(LW), .SPAN_W(SW)
  ) uut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .miss_ctx(miss_ctx), .per_ctx_en(per_ctx_en), .page_stop_en(page_stop_en),
    .lat_cfg(lat_cfg), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_lat(pf_lat), .span_total(span_total)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference state
  logic [AW-1:0] m_last [CN];
  logic [AW-1:0] m_prev [CN];
  logic [SW-1:0] m_span;
  logic [LW-1:0] m_lat;
  logic          pce, pse;
  logic [LW-1:0] lat_now;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [AW-1:0] a,
                      input logic [1:0] cx, input string tag);
    logic [AW-1:0] blk, ns, os, ca;
    logic [AW-1:0] e_addr [DG];
    logic [DG-1:0] e_valid;
    int ci, kept;
    bit hit, stop;
    blk  = a & ~AW'((1 << BB) - 1);
    ci   = pce ? int'(cx) : 0;
    ns   = blk - m_last[ci];
    os   = m_last[ci] - m_prev[ci];
    hit  = v && (ns == os);
    stop = 0;
    kept = 0;
    e_valid = '0;
    for (int d = 0; d < DG; d++) begin
      ca = blk + AW'(d + 1) * ns;
      e_addr[d] = ca;
      if (pse && (ca[AW-1:PB] != blk[AW-1:PB])) stop = 1;
      if (hit && !stop) begin
        e_valid[d] = 1'b1;
        kept++;
      end
    end
    if (hit && pse) m_span = m_span + SW'(DG - kept);
    if (v) begin
      m_prev[ci] = m_last[ci];
      m_last[ci] = blk;
      m_lat      = lat_now;
    end
    miss_valid   = v;
    miss_addr    = a;
    miss_ctx     = cx;
    per_ctx_en   = pce;
    page_stop_en = pse;
    lat_cfg      = lat_now;
    @(posedge clk);
    #1;
    chk(pf_valid == e_valid, tag, "lane valid", 32'(pf_valid), 32'(e_valid));
    for (int d = 0; d < DG; d++)
      if (e_valid[d])
        chk(pf_addr[d*AW +: AW] == e_addr[d], tag, "lane address",
            32'(pf_addr[d*AW +: AW]), 32'(e_addr[d]));
    chk(span_total == m_span, tag, "page span count", 32'(span_total), 32'(m_span));
    chk(pf_lat == m_lat, tag, "latency", 32'(pf_lat), 32'(m_lat));
    @(negedge clk);
    miss_valid = 1'b0;
    lat_now = lat_now + LW'(7);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int k = 0; k < CN; k++) begin
      m_last[k] = '0;
      m_prev[k] = '0;
    end
    m_span = '0; m_lat = '0; lat_now = 8'h11;
    pce = 1'b1; pse = 1'b0;
    rst = 1'b1; miss_valid = 1'b0; miss_addr = '0; miss_ctx = '0;
    per_ctx_en = 1'b1; page_stop_en = 1'b0; lat_cfg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state at the ports
    chk(pf_valid == '0, "R1", "reset lane valid", 32'(pf_valid), 0);
    chk(span_total == '0, "R1", "reset span", 32'(span_total), 0);
    chk(pf_lat == '0, "R1", "reset latency", 32'(pf_lat), 0);
    @(negedge clk);

    // R1: zeroed history gives equal zero strides on a miss to block 0
    step(1'b1, 16'h0000, 2'd2, "R1");
    step(1'b1, 16'h0001, 2'd3, "R1");

    // R2 R3 R4 R5: back-to-back stride runs, no page stop
    pce = 1'b1; pse = 1'b0;
    for (int c = 0; c < CN; c++)
      for (int s = -20; s <= 20; s += 3) begin
        logic [AW-1:0] b;
        b = AW'(c * 16'h3a71 + s * 16'h0107);
        step(1'b1, b, 2'(c), "R2");
        step(1'b1, b + AW'(s * 4) + AW'(s & 3), 2'(c), "R5");
        step(1'b1, b + AW'(s * 8), 2'(c), "R3");
        step(1'b1, b + AW'(s * 12) + AW'(c), 2'(c), "R4");
      end

    // R3: arithmetic wrap at the top of the address space
    step(1'b1, 16'hFFF0, 2'd1, "R3");
    step(1'b1, 16'hFFF8, 2'd1, "R3");
    step(1'b1, 16'h0000, 2'd1, "R3");

    // R6: interleaved contexts, separate then shared history
    for (int mode = 0; mode < 2; mode++) begin
      pce = (mode == 0);
      for (int k = 0; k < 4; k++)
        for (int c = 0; c < CN; c++)
          step(1'b1, AW'(c * 16'h0400 + k * (c + 1) * 4), 2'(c), "R6");
    end
    pce = 1'b1;

    // R11: idle cycles between a run leave history intact
    step(1'b1, 16'h2000, 2'd0, "R11");
    step(1'b1, 16'h2010, 2'd0, "R11");
    for (int k = 0; k < 3; k++) step(1'b0, 16'h5555, 2'd0, "R11");
    step(1'b1, 16'h2020, 2'd0, "R11");

    // R7 R8 R9 R10: page stop sweeps starting near page edges
    for (int mode = 0; mode < 2; mode++) begin
      pse = (mode == 0);
      for (int s = -40; s <= 40; s += 2)
        for (int e = 0; e < 2; e++) begin
          logic [AW-1:0] b;
          b = AW'(16'h4000 + s * 16'h0100 + (e ? 16'h00f0 : 16'h0008) - s * 4);
          step(1'b1, b, 2'(e), "R7");
          step(1'b1, b + AW'(s * 4), 2'(e), "R8");
          step(1'b1, b + AW'(s * 8), 2'(e), mode == 0 ? "R8" : "R9");
          step(1'b1, b + AW'(s * 12), 2'(e), "R10");
        end
    end

    report();
  end

endmodule